// File: doc/BRIEF.md
# Palette Color Lookup Table with Register Write Port

This block is a 256-entry color lookup table. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue component. Software loads the table through a small register window of four 32-bit word slots. The window is decoded on word address bits 3:2 only, so it covers 16 bytes. One slot selects an entry. A second slot takes the color components one at a time. Every write to a data register takes its byte from the top eight bits of the bus word.

A sequencing phase decides which component the next data write fills. The order is red first, then green, then blue. Once an entry is complete, the entry pointer moves on by one and wraps from 255 to 0. A whole palette can therefore be loaded with a single index write followed by a stream of data writes.

A pixel pipeline reads the table through a separate synchronous lookup port with one cycle of latency. Bus reads of the register window always return zero.

Top module: `clut_dac`

## Requirements
- R1: While reset is high (synchronous, active high), and after it falls, every entry reads as 0x000000 on the lookup port, except entry 255, which reads as 0xFFFFFF. The entry pointer is 0, the phase is red, and `pix_rgb` is 0 while in reset.
- R2: A write with `bus_addr` = 2'b00 (byte offset 0) loads the entry pointer from `bus_wdata[31:24]` and returns the phase to red.
- R3: A write with `bus_addr` = 2'b01 (byte offset 4) stores `bus_wdata[31:24]` into one component of the pointed entry, chosen by the phase in the order red, green, blue. The other two components of that entry keep their values. On `pix_rgb`, red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R4: The data write that fills blue advances the entry pointer by one, modulo 256 (255 goes to 0), and returns the phase to red.
- R5: Writes with `bus_addr` = 2'b10 or 2'b11 (byte offsets 8 and 12) change no entry, no pointer and no phase.
- R6: `bus_rdata` is zero in every cycle.
- R7: `pix_rgb` is registered. After the clock edge that samples `pix_idx`, it shows the contents of that entry as they were before that edge. A component written at edge N therefore appears at edge N+1.
- R8: An index write in the middle of a color sequence abandons the partly written triple. The next data write goes to red of the newly pointed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 2 | Word address (byte offset bits 3:2) within the register window |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Lookup index from the pixel pipeline |
| pix_rgb | output | 24 | Looked-up color {red, green, blue} |

## Verification
Register writes take effect at the edge that samples the strobe, but they can only be seen through the lookup port. That port adds one more register, so a component written at edge N is first visible after edge N+1, and the looked-up color for an index presented at edge N appears after edge N. The bench drives every input on the falling edge. Its behavioural model predicts `pix_rgb` at each rising edge from the table state before that edge, and the prediction is compared with the output on the following falling edge. Directed checks call out the cycles where an old value must still be showing, right after a write edge, and the cycle where the new value must appear.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int BUS_W  = 32;
    localparam int IDX_W  = 8;
    localparam int COMP_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    typedef enum logic [SEL_W-1:0] {
        SLOT_INDEX = 2'd0,
        SLOT_DATA  = 2'd1,
        SLOT_NONE0 = 2'd2,
        SLOT_NONE1 = 2'd3
    } slot_e;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
        logic [COMP_W-1:0] blu;
    } rgb_t;

    function automatic logic phase_legal(input phase_e ph);
        return (ph == PH_RED) || (ph == PH_GRN) || (ph == PH_BLU);
    endfunction

    function automatic phase_e phase_after(input phase_e ph);
        case (ph)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int CW = COMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  slot_e         slot,
    input  logic [IW-1:0] idx_byte,
    input  logic [CW-1:0] comp_byte,
    output logic          ent_we,
    output phase_e        ent_ph,
    output logic [IW-1:0] ent_idx,
    output logic [CW-1:0] ent_byte
);

    logic [IW-1:0] ptr_q;
    phase_e        ph_q;
    logic          hit_index;
    logic          hit_data;

    assign hit_index = wr && (slot == SLOT_INDEX);
    assign hit_data  = wr && (slot == SLOT_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            ph_q  <= PH_RED;
        end else if (hit_index) begin
            ptr_q <= idx_byte;
            ph_q  <= PH_RED;
        end else if (hit_data) begin
            ph_q <= phase_after(ph_q);
            if (ph_q == PH_BLU) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign ent_we   = hit_data && phase_legal(ph_q);
    assign ent_ph   = ph_q;
    assign ent_idx  = ptr_q;
    assign ent_byte = comp_byte;

    assert_index_resets_phase_R2: assert property (@(posedge clk) disable iff (rst)
        hit_index |=> (ph_q == PH_RED) && (ptr_q == $past(idx_byte)));

    assert_blue_advances_R4: assert property (@(posedge clk) disable iff (rst)
        (hit_data && ph_q == PH_BLU) |=> (ph_q == PH_RED) && (ptr_q == $past(ptr_q) + 1'b1));

    assert_spare_slots_inert_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && (slot == SLOT_NONE0 || slot == SLOT_NONE1)) |=> $stable(ptr_q) && $stable(ph_q));

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int CW = COMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  phase_e        ph,
    input  logic [IW-1:0] widx,
    input  logic [CW-1:0] wbyte,
    input  logic [IW-1:0] ridx,
    output rgb_t          rdata
);

    localparam int DEPTH = 1 << IW;

    rgb_t table_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < DEPTH; e++) begin
                table_q[e] <= (e == DEPTH - 1) ? '1 : '0;
            end
            rdata <= '0;
        end else begin
            if (we) begin
                case (ph)
                    PH_RED:  table_q[widx].red <= wbyte;
                    PH_GRN:  table_q[widx].grn <= wbyte;
                    default: table_q[widx].blu <= wbyte;
                endcase
            end
            rdata <= table_q[ridx];
        end
    end

    assert_red_only_R3: assert property (@(posedge clk) disable iff (rst)
        (we && ph == PH_RED) |=>
            (table_q[$past(widx)].red == $past(wbyte)) &&
            (table_q[$past(widx)].grn == $past(table_q[widx].grn)) &&
            (table_q[$past(widx)].blu == $past(table_q[widx].blu)));

endmodule

// File: rtl/clut_dac.sv
module clut_dac
    import clut_pkg::*;
#(
    parameter int BW = BUS_W,
    parameter int IW = IDX_W,
    parameter int CW = COMP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic [3:2]      bus_addr,
    input  logic [BW-1:0]   bus_wdata,
    output logic [BW-1:0]   bus_rdata,
    input  logic [IW-1:0]   pix_idx,
    output logic [3*CW-1:0] pix_rgb
);

    logic          ent_we;
    phase_e        ent_ph;
    logic [IW-1:0] ent_idx;
    logic [CW-1:0] ent_byte;
    rgb_t          look_q;
    logic          unused_lo;

    assign unused_lo = ^bus_wdata[BW-CW-1:0];

    clut_seq #(.IW(IW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .slot      (slot_e'(bus_addr)),
        .idx_byte  (bus_wdata[BW-1 -: IW]),
        .comp_byte (bus_wdata[BW-1 -: CW]),
        .ent_we    (ent_we),
        .ent_ph    (ent_ph),
        .ent_idx   (ent_idx),
        .ent_byte  (ent_byte)
    );

    clut_store #(.IW(IW), .CW(CW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (ent_we),
        .ph    (ent_ph),
        .widx  (ent_idx),
        .wbyte (ent_byte),
        .ridx  (pix_idx),
        .rdata (look_q)
    );

    assign pix_rgb   = look_q;
    assign bus_rdata = '0;

    assert_lookup_idle_in_reset_R1: assert property (@(posedge clk)
        rst |=> (pix_rgb == '0));

endmodule

// File: tb/clut_dac_test.sv
`timescale 1ns/1ps
module clut_dac_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:2]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int compared = 0;
    int mismatched = 0;
    bit model_live = 0;
    string cur_req = "R1";

    logic [7:0]  m_r [256];
    logic [7:0]  m_g [256];
    logic [7:0]  m_b [256];
    logic [7:0]  m_idx;
    int          m_ph;
    logic [23:0] exp_rgb;

    always #2 clk = ~clk;

    clut_dac uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] want);
        compared++;
        if (got !== want) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, want, $time);
        end
    endtask

    // Behavioural reference, evaluated on the state before each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            exp_rgb = '0;
            for (int e = 0; e < 256; e++) begin
                m_r[e] = 8'h00; m_g[e] = 8'h00; m_b[e] = 8'h00;
            end
            m_r[255] = 8'hFF; m_g[255] = 8'hFF; m_b[255] = 8'hFF;
            m_idx = 8'd0;
            m_ph = 0;
        end else begin
            exp_rgb = {m_r[pix_idx], m_g[pix_idx], m_b[pix_idx]};
            if (bus_wr && bus_addr == 2'd0) begin
                m_idx = bus_wdata[31:24];
                m_ph = 0;
            end else if (bus_wr && bus_addr == 2'd1) begin
                if (m_ph == 0) begin
                    m_r[m_idx] = bus_wdata[31:24]; m_ph = 1;
                end else if (m_ph == 1) begin
                    m_g[m_idx] = bus_wdata[31:24]; m_ph = 2;
                end else begin
                    m_b[m_idx] = bus_wdata[31:24];
                    m_idx = m_idx + 8'd1;
                    m_ph = 0;
                end
            end
        end
        model_live = 1;
    end

    always @(negedge clk) begin
        if (model_live) begin
            chk({cur_req, " pix_rgb vs model (R7)"}, {8'h00, pix_rgb}, {8'h00, exp_rgb});
            chk("R6 bus_rdata", bus_rdata, 32'h0);
        end
    end

    task automatic wr(input logic [3:0] off, input logic [7:0] top);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = off[3:2];
        bus_wdata = {top, 24'hA5C35A};
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic look(input logic [7:0] idx, input logic [23:0] want, input string tag);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        chk(tag, {8'h00, pix_rgb}, {8'h00, want});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pix_rgb in reset", {8'h00, pix_rgb}, 32'h0);
        rst = 1'b0;
        cur_req = "R1";
        look(8'd0,   24'h000000, "R1 entry 0 black");
        look(8'd255, 24'hFFFFFF, "R1 entry 255 white");
        look(8'd128, 24'h000000, "R1 entry 128 black");

        cur_req = "R3";
        wr(4'h0, 8'd10);
        wr(4'h4, 8'h12);
        look(8'd10, 24'h120000, "R3 red only");
        wr(4'h4, 8'h34);
        wr(4'h4, 8'h56);
        look(8'd10, 24'h123456, "R3 full triple");
        look(8'd11, 24'h000000, "R3 neighbour untouched");

        cur_req = "R4";
        wr(4'h4, 8'hAA); wr(4'h4, 8'hBB); wr(4'h4, 8'hCC);
        look(8'd11, 24'hAABBCC, "R4 autoincrement");
        wr(4'h0, 8'd255);
        wr(4'h4, 8'h01); wr(4'h4, 8'h02); wr(4'h4, 8'h03);
        wr(4'h4, 8'h04); wr(4'h4, 8'h05); wr(4'h4, 8'h06);
        look(8'd255, 24'h010203, "R4 entry 255");
        look(8'd0,   24'h040506, "R4 wrap to 0");

        cur_req = "R8";
        wr(4'h0, 8'd20);
        wr(4'h4, 8'h77);
        wr(4'h0, 8'd20);
        wr(4'h4, 8'h11); wr(4'h4, 8'h22); wr(4'h4, 8'h33);
        look(8'd20, 24'h112233, "R8 restart at red");

        cur_req = "R5";
        wr(4'h0, 8'd30);
        wr(4'h4, 8'h40);
        wr(4'h8, 8'hFF);
        wr(4'hC, 8'hEE);
        wr(4'h4, 8'h50); wr(4'h4, 8'h60);
        look(8'd30, 24'h405060, "R5 spare slots ignored");
        look(8'd31, 24'h000000, "R5 next entry untouched");
        wr(4'h8, 8'd99);
        wr(4'h4, 8'h70); wr(4'h4, 8'h71); wr(4'h4, 8'h72);
        look(8'd31, 24'h707172, "R5 pointer unchanged by spare slot");

        cur_req = "R7";
        @(negedge clk);
        pix_idx = 8'd50;
        wr(4'h0, 8'd50);
        wr(4'h4, 8'h81);
        chk("R7 red not yet visible", {8'h00, pix_rgb}, 32'h000000);
        @(negedge clk);
        chk("R7 red visible next cycle", {8'h00, pix_rgb}, 32'h810000);
        wr(4'h4, 8'h82);
        wr(4'h4, 8'h83);
        chk("R7 blue not yet visible", {8'h00, pix_rgb}, 32'h818200);
        @(negedge clk);
        chk("R7 blue visible next cycle", {8'h00, pix_rgb}, 32'h818283);

        cur_req = "R1";
        wr(4'h0, 8'd60);
        wr(4'h4, 8'h99);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 pix_rgb in second reset", {8'h00, pix_rgb}, 32'h0);
        rst = 1'b0;
        look(8'd255, 24'hFFFFFF, "R1 entry 255 white again");
        look(8'd10,  24'h000000, "R1 entry 10 cleared");
        wr(4'h4, 8'hA1); wr(4'h4, 8'hB2); wr(4'h4, 8'hC3);
        look(8'd0, 24'hA1B2C3, "R1 pointer and phase cleared");
        look(8'd60, 24'h000000, "R1 partial entry cleared");

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule